// File: doc/BRIEF.md
# Pin Bank with Per-Pin Interrupt Triggers

This block is a bank of general-purpose pins, 32 by default, controlled through a small memory-mapped register port. Each pin has a drive value and a direction bit. Its external level can be read back after a two-flop synchronizer. Every register holds one bit per pin, and bit n always belongs to pin n.

Each pin can raise an interrupt. Two per-pin bits choose the trigger: a kind bit selects edge or level, and a sense bit selects rising or falling for edges, and high or low for levels. An enable bit gates the raw status. A mask bit removes the pin from the masked status and from the single combined interrupt line. Edge events are held by a per-pin two-state machine. In `EV_IDLE` no event is pending. The transition "capture" goes to `EV_HELD` when a qualifying edge is seen. The transition "acknowledge" returns to `EV_IDLE` on an end-of-interrupt write with that pin's bit set and no new edge in the same cycle. The transition "demote" returns to `EV_IDLE` when the pin is switched to level mode.

Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset, drive value (0x00), direction (0x04), enable (0x30), kind (0x38) and sense (0x3C) read 0, mask (0x34) reads all ones, both status registers read 0 and `irq` is 0.
- R2: Drive value (0x00) and direction (0x04) read back as written. `pin_out` equals the drive register, and `pin_oe` equals the direction register, where 1 means output.
- R3: Reading 0x50 returns the `pin_in` levels two clock edges after they are applied.
- R4: A pin with kind bit 0 (level) has raw status (0x44) equal to 1 exactly while its synchronized level equals its sense bit.
- R5: A pin with kind bit 1 (edge) sets its raw status bit on a rising edge when sense is 1, or on a falling edge when sense is 0. The bit stays set after the input returns.
- R6: A write to 0x4C clears the held edge event of every edge-mode pin whose bit is 1 in the write data. Other pins are untouched, and level-mode pins are not affected.
- R7: When an acknowledge and a new qualifying edge on the same pin fall in the same cycle, the pin's status stays set.
- R8: Masked status (0x40) equals raw status AND NOT mask, and `irq` is the OR of masked status.
- R9: A pin whose enable bit is 0 has raw status 0 whatever its level or held event.
- R10: Reads of unmapped offsets return 0. Writes to 0x40, 0x44 and 0x50 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 32 | External pin levels, asynchronous |
| pin_out | output | 32 | Drive value per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `pin_in` may change at any time but is held for at least three clocks, so that the synchronizer and edge comparator see every transition. They also assume that the write strobe is a clean single-cycle pulse with stable address and data. The stimulus changes pins and register controls only on the falling clock edge. It leaves at least four cycles between a pin change and any status read. The one exception is the case of an acknowledge and an edge in the same cycle, where the write is placed deliberately on the cycle in which the edge is detected.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    localparam logic [7:0] OFF_DRIVE  = 8'h00;
    localparam logic [7:0] OFF_DIR    = 8'h04;
    localparam logic [7:0] OFF_ENABLE = 8'h30;
    localparam logic [7:0] OFF_MASK   = 8'h34;
    localparam logic [7:0] OFF_KIND   = 8'h38;
    localparam logic [7:0] OFF_SENSE  = 8'h3C;
    localparam logic [7:0] OFF_MSTAT  = 8'h40;
    localparam logic [7:0] OFF_RSTAT  = 8'h44;
    localparam logic [7:0] OFF_ACK    = 8'h4C;
    localparam logic [7:0] OFF_LEVEL  = 8'h50;

    typedef enum logic {
        EV_IDLE = 1'b0,
        EV_HELD = 1'b1
    } ev_state_e;

endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stg_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            stg_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) begin
                stg_q[k] <= stg_q[k-1];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign lvl      = stg_q[STAGES-1];
    assign lvl_prev = prev_q;

endmodule

// File: rtl/pin_bank_trig.sv
module pin_bank_trig
    import pin_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic en,
    input  logic kind_edge,
    input  logic sense,
    input  logic ack,
    output logic raw
);

    ev_state_e state_q, state_d;
    logic      hit;

    assign hit = kind_edge && en &&
                 (sense ? (lvl && !lvl_prev) : (!lvl && lvl_prev));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: begin
                if (hit) state_d = EV_HELD;
            end
            EV_HELD: begin
                if (!kind_edge)       state_d = EV_IDLE;
                else if (hit)         state_d = EV_HELD;
                else if (ack)         state_d = EV_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!en)            raw = 1'b0;
        else if (kind_edge) raw = (state_q == EV_HELD);
        else                raw = (lvl == sense);
    end

    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> state_q == EV_HELD);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_HELD && kind_edge && ack && !hit) |=> state_q == EV_IDLE);

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !raw);

endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [PINS-1:0]   wdata,
    input  logic [PINS-1:0]   raw_in,
    input  logic [PINS-1:0]   lvl_in,
    output logic [PINS-1:0]   rdata,
    output logic [PINS-1:0]   drive,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   en,
    output logic [PINS-1:0]   mask,
    output logic [PINS-1:0]   kind,
    output logic [PINS-1:0]   sense,
    output logic [PINS-1:0]   ack,
    output logic [PINS-1:0]   masked
);

    localparam logic [ADDR_W-1:0] A_DRIVE  = ADDR_W'(OFF_DRIVE);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_KIND   = ADDR_W'(OFF_KIND);
    localparam logic [ADDR_W-1:0] A_SENSE  = ADDR_W'(OFF_SENSE);
    localparam logic [ADDR_W-1:0] A_MSTAT  = ADDR_W'(OFF_MSTAT);
    localparam logic [ADDR_W-1:0] A_RSTAT  = ADDR_W'(OFF_RSTAT);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_LEVEL  = ADDR_W'(OFF_LEVEL);

    logic [PINS-1:0] drive_q, dir_q, en_q, mask_q, kind_q, sense_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
            dir_q   <= '0;
            en_q    <= '0;
            mask_q  <= '1;
            kind_q  <= '0;
            sense_q <= '0;
        end else if (wr) begin
            case (addr)
                A_DRIVE:  drive_q <= wdata;
                A_DIR:    dir_q   <= wdata;
                A_ENABLE: en_q    <= wdata;
                A_MASK:   mask_q  <= wdata;
                A_KIND:   kind_q  <= wdata;
                A_SENSE:  sense_q <= wdata;
                default:  ;
            endcase
        end
    end

    assign ack    = (wr && addr == A_ACK) ? wdata : '0;
    assign masked = raw_in & ~mask_q;

    always_comb begin
        case (addr)
            A_DRIVE:  rdata = drive_q;
            A_DIR:    rdata = dir_q;
            A_ENABLE: rdata = en_q;
            A_MASK:   rdata = mask_q;
            A_KIND:   rdata = kind_q;
            A_SENSE:  rdata = sense_q;
            A_MSTAT:  rdata = masked;
            A_RSTAT:  rdata = raw_in;
            A_LEVEL:  rdata = lvl_in;
            default:  rdata = '0;
        endcase
    end

    assign drive = drive_q;
    assign dir   = dir_q;
    assign en    = en_q;
    assign mask  = mask_q;
    assign kind  = kind_q;
    assign sense = sense_q;

    // R2
    drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_DRIVE) |=> drive_q == $past(wdata));

    // R10
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_MSTAT || addr == A_RSTAT || addr == A_LEVEL)) |=>
        ($stable(drive_q) && $stable(dir_q) && $stable(en_q) &&
         $stable(mask_q) && $stable(kind_q) && $stable(sense_q)));

endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq
    import pin_bank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PINS-1:0]   reg_wdata,
    output logic [PINS-1:0]   reg_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);

    logic [PINS-1:0] lvl, lvl_prev, raw, masked;
    logic [PINS-1:0] en, mask, kind, sense, ack;

    pin_bank_sync #(.WIDTH(PINS), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    pin_bank_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .raw_in (raw),
        .lvl_in (lvl),
        .rdata  (reg_rdata),
        .drive  (pin_out),
        .dir    (pin_oe),
        .en     (en),
        .mask   (mask),
        .kind   (kind),
        .sense  (sense),
        .ack    (ack),
        .masked (masked)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        pin_bank_trig u_trig (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl[g]),
            .lvl_prev  (lvl_prev[g]),
            .en        (en[g]),
            .kind_edge (kind[g]),
            .sense     (sense[g]),
            .ack       (ack[g]),
            .raw       (raw[g])
        );
    end

    assign irq = |masked;

    // R8
    irq_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '1));

endmodule

// File: tb/pin_bank_irq_tb.sv
module pin_bank_irq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    pin_bank_irq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] pol, pv, en, mk, expv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1", 8'h00, 32'h0); rd("R1", 8'h04, 32'h0); rd("R1", 8'h30, 32'h0);
        rd("R1", 8'h34, 32'hFFFF_FFFF); rd("R1", 8'h38, 32'h0); rd("R1", 8'h3C, 32'h0);
        rd("R1", 8'h40, 32'h0); rd("R1", 8'h44, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 walking-one sweep of drive and direction
        for (int i = 0; i < 32; i++) begin
            wr(8'h00, 32'h1 << i);
            wr(8'h04, ~(32'h1 << i));
            rd("R2", 8'h00, 32'h1 << i);
            rd("R2", 8'h04, ~(32'h1 << i));
            chk("R2 pin_out", pin_out, 32'h1 << i);
            chk("R2 pin_oe", pin_oe, ~(32'h1 << i));
        end

        // R3 input level readback after two edges
        for (int i = 0; i < 8; i++) begin
            pv = 32'h9E37_79B9 * (i + 1);
            pin_in = pv;
            @(negedge clk); @(negedge clk);
            rd("R3", 8'h50, pv);
        end

        // R10 unmapped reads and ignored writes
        rd("R10", 8'h08, 32'h0); rd("R10", 8'h2C, 32'h0); rd("R10", 8'h48, 32'h0);
        rd("R10", 8'h54, 32'h0); rd("R10", 8'hFC, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF); wr(8'h50, 32'h1234_5678);
        rd("R10", 8'h00, 32'h8000_0000); rd("R10", 8'h04, 32'h7FFF_FFFF);
        rd("R10", 8'h30, 32'h0); rd("R10", 8'h34, 32'hFFFF_FFFF);
        rd("R10", 8'h44, 32'h0); rd("R10", 8'h50, pv);

        // R4 R9 R8 level-mode sweep over sense, pin and enable patterns
        wr(8'h38, 32'h0);
        for (int s = 0; s < 3; s++) begin
            pol = (s == 0) ? 32'h0 : (s == 1) ? 32'hFFFF_FFFF : 32'hA5A5_A5A5;
            wr(8'h3C, pol);
            for (int p = 0; p < 4; p++) begin
                pv = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF : 32'h0F0F_3C3C * (p + s);
                for (int e = 0; e < 2; e++) begin
                    en = (e == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                    mk = (e == 0) ? 32'h0 : 32'h00FF_00F0;
                    wr(8'h30, en);
                    wr(8'h34, mk);
                    pin_in = pv;
                    settle();
                    expv = en & ~(pv ^ pol);
                    rd((e == 0) ? "R4" : "R9", 8'h44, expv);
                    rd("R8", 8'h40, expv & ~mk);
                    chk("R8 irq", {31'h0, irq}, {31'h0, |(expv & ~mk)});
                end
            end
        end
        wr(8'h34, 32'hFFFF_FFFF);
        chk("R8 all masked irq", {31'h0, irq}, 32'h0);
        wr(8'h34, 32'h0);

        // R5 edge capture: low half rising, high half falling
        pin_in = 32'h0; settle();
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0000_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd("R5 idle", 8'h44, 32'h0);
        pin_in = 32'hFFFF_FFFF; settle();
        rd("R5 rise", 8'h44, 32'h0000_FFFF);
        pin_in = 32'h0; settle();
        rd("R5 fall sticky", 8'h44, 32'hFFFF_FFFF);

        // R6 partial acknowledge
        wr(8'h4C, 32'h0000_00FF);
        rd("R6 partial", 8'h44, 32'hFFFF_FF00);
        // R6 level pins ignore acknowledge: low half level, sense 0, pins low
        wr(8'h38, 32'hFFFF_0000);
        wr(8'h3C, 32'h0);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd("R6 level kept", 8'h44, 32'h0000_FFFF);

        // R7 acknowledge in the same cycle as a new edge
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0018; settle();
        rd("R7 setup", 8'h44, 32'h0000_0018);
        pin_in = 32'h0; settle();
        pin_in = 32'h0000_0008;
        @(negedge clk); @(negedge clk);
        wr(8'h4C, 32'h0000_0018);
        rd("R7 edge wins", 8'h44, 32'h0000_0008);
        settle();
        rd("R7 after", 8'h44, 32'h0000_0008);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule